// File: doc/BRIEF.md
# Register-Driven Serial EEPROM Master

This block moves single bytes to and from a serial EEPROM, or any similar two-wire slave, over an I2C bus. The host programs a small register file. The device select register holds a 4-bit device-type nibble and a 3-bit chip-select field. Separate registers hold the word address and the byte to be written. The host then sets one start bit in the status register. The engine runs a complete single-byte write, or a random read that uses a repeated START. When the transfer ends it clears the start bit, raises a finish flag and, on request, an interrupt.

The bus pins are open-drain. The block only pulls SCL or SDA low, and it reads SDA back through `sda_in`. Each bit on the wire lasts four quarter periods of `QTR_CYCLES` clocks. SDA moves in the first quarter while SCL is low. SCL is high for the middle two quarters, and SDA is sampled in the third quarter. A slave that does not acknowledge any transmitted byte ends the transfer early with a STOP. The NAK flag is then set next to the normal finish flag.

Register offsets on `reg_addr`: 0 interrupt enable, 1 status, 2 write data, 3 read data (read-only), 4 device select, 5 word address. Unused offsets read as zero.

Top module: `eeprom_i2c_master`

## Requirements
- R1: After reset, both bus pins are released. Every register reads 0 and `irq` is 0. While no transfer runs, both pins stay released.
- R2: The address byte on the wire is {devsel[3:0], devsel[6:4], rw}. Bits 3:0 of the device select register give the upper nibble of the 7-bit slave address, and bits 6:4 give the chip-select bits A2..A0. rw is 0 for write and 1 for read.
- R3: A write sends START, the address byte with rw=0, the word address, the write-data byte and STOP, each byte MSB first and each followed by an acknowledge bit.
- R4: A read sends START, the address byte with rw=0 and the word address. It then sends a repeated START and the address byte with rw=1, receives one byte and answers it with NACK (SDA released), then sends STOP. The received byte appears at offset 3.
- R5: Writing 1 to status bit 1 starts a write, and writing 1 to status bit 3 starts a read. The bit reads 1 for the whole transfer and returns to 0 by itself at the end. If both bits are written together, only the write runs.
- R6: A start request written while a transfer is pending or running is ignored. The running transfer is not disturbed and no second transfer follows.
- R7: Status bit 0 (write finished) and bit 2 (read finished) are set when a transfer ends. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: If the slave answers any transmitted byte with NAK (SDA high in the acknowledge slot), the engine sends STOP at once. Status bit 7 (NAK) and the finish flag are both set, and the read data register keeps its old value. Bit 7 is cleared by writing 1 to it.
- R9: `irq` is 1 exactly when enable bit 7 is set and either enable bit 1 and the read-finish flag are both set, or enable bit 0 and the write-finish flag are both set.
- R10: SCL stays low and stays high for at least two quarter periods each time. SDA changes while SCL is high only as part of a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Transfer-finished interrupt |
| scl_pull | output | 1 | 1 pulls the SCL line low, 0 releases it |
| sda_pull | output | 1 | 1 pulls the SDA line low, 0 releases it |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
The bench builds the block with `QTR_CYCLES` = 2, so one bus bit takes eight clocks and a full random read fits in a few hundred cycles. Even at this setting, a shortened SCL phase or a one-quarter slip of SDA against SCL changes the measured high and low times and the bit order that the bench's slave model decodes. A slave model answers with ACK or NAK at any chosen byte, which reaches both early-abort paths as well as the full write and read sequences.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

  // Bus operations making up a transfer, stepped one after another.
  typedef enum logic [2:0] {
    OP_START,
    OP_TX_DEVW,
    OP_TX_WADR,
    OP_TX_DATA,
    OP_TX_DEVR,
    OP_RX,
    OP_STOP
  } op_e;

  localparam int STEP_W = 3;

  // Register offsets
  localparam int OFF_IEN  = 0;
  localparam int OFF_STAT = 1;
  localparam int OFF_WDAT = 2;
  localparam int OFF_RDAT = 3;
  localparam int OFF_DEVS = 4;
  localparam int OFF_WADR = 5;

  // Operation at a given step of a write (rd=0) or random read (rd=1).
  function automatic op_e seq_op(input logic rd, input logic [STEP_W-1:0] step);
    op_e r;
    case (step)
      3'd0:    r = OP_START;
      3'd1:    r = OP_TX_DEVW;
      3'd2:    r = OP_TX_WADR;
      3'd3:    r = rd ? OP_START : OP_TX_DATA;
      3'd4:    r = rd ? OP_TX_DEVR : OP_STOP;
      3'd5:    r = rd ? OP_RX : OP_STOP;
      default: r = OP_STOP;
    endcase
    return r;
  endfunction

  // Step index of the closing STOP, used when a NAK aborts a transfer.
  function automatic logic [STEP_W-1:0] stop_step(input logic rd);
    return rd ? 3'd6 : 3'd4;
  endfunction

  // Address byte on the wire from the device select register.
  function automatic logic [7:0] addr_byte(input logic [6:0] devsel, input logic rw);
    return {devsel[3:0], devsel[6:4], rw};
  endfunction

endpackage

// File: rtl/eeprom_i2c_qtick.sv
module eeprom_i2c_qtick #(
  parameter int QTR_CYCLES = 94
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(QTR_CYCLES + 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(QTR_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/eeprom_i2c_seq.sv
module eeprom_i2c_seq
  import eeprom_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       launch,
  input  logic       launch_rd,
  input  logic [6:0] devsel,
  input  logic [7:0] word_adr,
  input  logic [7:0] wr_byte,
  input  logic       sda_in,
  output logic       busy,
  output logic       scl_low,
  output logic       sda_low,
  output logic       done,
  output logic       done_nak,
  output logic [7:0] rx_byte,
  output op_e        cur_op
);
  logic              rd_q;
  logic [STEP_W-1:0] step;
  logic [1:0]        ph;
  logic [3:0]        bitn;
  logic              nak_q;
  logic [7:0]        tx_byte;
  logic              last_bit;

  assign cur_op   = seq_op(rd_q, step);
  assign last_bit = (bitn == 4'd8);

  always_comb begin
    case (cur_op)
      OP_TX_DEVW: tx_byte = addr_byte(devsel, 1'b0);
      OP_TX_DEVR: tx_byte = addr_byte(devsel, 1'b1);
      OP_TX_WADR: tx_byte = word_adr;
      default:    tx_byte = wr_byte;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rd_q     <= 1'b0;
      step     <= '0;
      ph       <= '0;
      bitn     <= '0;
      nak_q    <= 1'b0;
      scl_low  <= 1'b0;
      sda_low  <= 1'b0;
      done     <= 1'b0;
      done_nak <= 1'b0;
      rx_byte  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (launch) begin
          busy  <= 1'b1;
          rd_q  <= launch_rd;
          step  <= '0;
          ph    <= '0;
          bitn  <= '0;
          nak_q <= 1'b0;
        end
      end else if (tick) begin
        ph <= ph + 2'd1;
        case (cur_op)
          OP_START: begin
            case (ph)
              2'd0:    sda_low <= 1'b0;
              2'd1:    scl_low <= 1'b0;
              2'd2:    sda_low <= 1'b1;
              default: begin
                scl_low <= 1'b1;
                step    <= step + 3'd1;
              end
            endcase
          end
          OP_STOP: begin
            case (ph)
              2'd0:    sda_low <= 1'b1;
              2'd1:    scl_low <= 1'b0;
              2'd2:    sda_low <= 1'b0;
              default: begin
                busy     <= 1'b0;
                done     <= 1'b1;
                done_nak <= nak_q;
              end
            endcase
          end
          OP_RX: begin
            case (ph)
              2'd0:    sda_low <= 1'b0;
              2'd1:    scl_low <= 1'b0;
              2'd2:    if (!last_bit) rx_byte <= {rx_byte[6:0], sda_in};
              default: begin
                scl_low <= 1'b1;
                if (last_bit) begin
                  bitn <= '0;
                  step <= step + 3'd1;
                end else begin
                  bitn <= bitn + 4'd1;
                end
              end
            endcase
          end
          default: begin
            case (ph)
              2'd0:    sda_low <= last_bit ? 1'b0 : ~tx_byte[3'd7 - bitn[2:0]];
              2'd1:    scl_low <= 1'b0;
              2'd2:    if (last_bit && sda_in) nak_q <= 1'b1;
              default: begin
                scl_low <= 1'b1;
                if (last_bit) begin
                  bitn <= '0;
                  step <= nak_q ? stop_step(rd_q) : step + 3'd1;
                end else begin
                  bitn <= bitn + 4'd1;
                end
              end
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_i2c_regs.sv
module eeprom_i2c_regs
  import eeprom_i2c_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              done_nak,
  input  logic [7:0]        rx_byte,
  output logic              launch,
  output logic              kind_rd,
  output logic [6:0]        devsel,
  output logic [7:0]        word_adr,
  output logic [7:0]        wr_byte,
  output logic              go_wr,
  output logic              go_rd,
  output logic              f_wdone,
  output logic              f_rdone,
  output logic              f_nak,
  output logic              irq
);
  logic [7:0] ien;
  logic [7:0] rd_byte;
  logic       engaged;

  assign engaged = busy | go_wr | go_rd;
  assign irq     = ien[7] & ((ien[1] & f_rdone) | (ien[0] & f_wdone));

  always_comb begin
    case (addr)
      ADDR_W'(OFF_IEN):  rdata = ien;
      ADDR_W'(OFF_STAT): rdata = {f_nak, 3'b000, go_rd, f_rdone, go_wr, f_wdone};
      ADDR_W'(OFF_WDAT): rdata = wr_byte;
      ADDR_W'(OFF_RDAT): rdata = rd_byte;
      ADDR_W'(OFF_DEVS): rdata = {1'b0, devsel};
      ADDR_W'(OFF_WADR): rdata = word_adr;
      default:           rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien      <= '0;
      rd_byte  <= '0;
      devsel   <= '0;
      word_adr <= '0;
      wr_byte  <= '0;
      go_wr    <= 1'b0;
      go_rd    <= 1'b0;
      f_wdone  <= 1'b0;
      f_rdone  <= 1'b0;
      f_nak    <= 1'b0;
      launch   <= 1'b0;
      kind_rd  <= 1'b0;
    end else begin
      launch <= 1'b0;
      if (we) begin
        case (addr)
          ADDR_W'(OFF_IEN):  ien <= wdata & 8'h83;
          ADDR_W'(OFF_WDAT): wr_byte <= wdata;
          ADDR_W'(OFF_DEVS): devsel <= wdata[6:0];
          ADDR_W'(OFF_WADR): word_adr <= wdata;
          ADDR_W'(OFF_STAT): begin
            if (wdata[0]) f_wdone <= 1'b0;
            if (wdata[2]) f_rdone <= 1'b0;
            if (wdata[7]) f_nak   <= 1'b0;
            if (!engaged) begin
              if (wdata[1]) begin
                go_wr   <= 1'b1;
                launch  <= 1'b1;
                kind_rd <= 1'b0;
              end else if (wdata[3]) begin
                go_rd   <= 1'b1;
                launch  <= 1'b1;
                kind_rd <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
      // completion has priority over a same-cycle clear
      if (done) begin
        go_wr <= 1'b0;
        go_rd <= 1'b0;
        if (kind_rd) f_rdone <= 1'b1;
        else         f_wdone <= 1'b1;
        if (done_nak)     f_nak   <= 1'b1;
        else if (kind_rd) rd_byte <= rx_byte;
      end
    end
  end
endmodule

// File: rtl/eeprom_i2c_master.sv
module eeprom_i2c_master
  import eeprom_i2c_pkg::*;
#(
  parameter int QTR_CYCLES = 94,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              sda_in
);
  logic       busy, qtick, launch, kind_rd;
  logic       seq_done, seq_nak;
  logic [6:0] devsel;
  logic [7:0] word_adr, wr_byte, rx_byte;
  logic       go_wr, go_rd, f_wdone, f_rdone, f_nak;
  op_e        cur_op;

  eeprom_i2c_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_qtick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(qtick)
  );

  eeprom_i2c_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .done(seq_done), .done_nak(seq_nak),
    .rx_byte(rx_byte), .launch(launch), .kind_rd(kind_rd), .devsel(devsel),
    .word_adr(word_adr), .wr_byte(wr_byte), .go_wr(go_wr), .go_rd(go_rd),
    .f_wdone(f_wdone), .f_rdone(f_rdone), .f_nak(f_nak), .irq(irq)
  );

  eeprom_i2c_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(qtick), .launch(launch), .launch_rd(kind_rd),
    .devsel(devsel), .word_adr(word_adr), .wr_byte(wr_byte), .sda_in(sda_in),
    .busy(busy), .scl_low(scl_pull), .sda_low(sda_pull), .done(seq_done),
    .done_nak(seq_nak), .rx_byte(rx_byte), .cur_op(cur_op)
  );
endmodule

// File: rtl/eeprom_i2c_master_chk.sv
module eeprom_i2c_master_chk
  import eeprom_i2c_pkg::*;
#(
  parameter int QTR_CYCLES = 94
) (
  input logic clk,
  input logic rst_n,
  input logic scl_pull,
  input logic sda_pull,
  input logic busy,
  input logic done,
  input logic done_nak,
  input logic go_wr,
  input logic go_rd,
  input logic f_wdone,
  input logic f_rdone,
  input logic f_nak,
  input logic irq,
  input op_e  cur_op
);
  localparam int CW = $clog2(4 * QTR_CYCLES + 2) + 1;

  logic [CW-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      if (scl_pull)           hi_cnt <= '0;
      else if (hi_cnt != '1)  hi_cnt <= hi_cnt + CW'(1);
      if (!scl_pull)          lo_cnt <= '0;
      else if (lo_cnt != '1)  lo_cnt <= lo_cnt + CW'(1);
    end
  end

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull && !sda_pull));

  // R5
  one_go_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (go_wr ^ go_rd));

  // R5
  go_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !(go_wr || go_rd));

  // R7
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  nak_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_nak) |=> (f_nak && (f_wdone || f_rdone)));

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (f_wdone || f_rdone));

  // R10
  scl_high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> (hi_cnt >= CW'(2 * QTR_CYCLES)));

  // R10
  scl_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull) |-> (lo_cnt >= CW'(2 * QTR_CYCLES)));

  // R10
  sda_edge_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull && $past(!scl_pull) && (sda_pull != $past(sda_pull)))
      |-> (cur_op == OP_START || cur_op == OP_STOP));
endmodule

bind eeprom_i2c_master eeprom_i2c_master_chk #(.QTR_CYCLES(QTR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .busy(busy), .done(seq_done), .done_nak(seq_nak), .go_wr(go_wr), .go_rd(go_rd),
  .f_wdone(f_wdone), .f_rdone(f_rdone), .f_nak(f_nak), .irq(irq), .cur_op(cur_op)
);

// File: tb/eeprom_i2c_master_tb.sv
module eeprom_i2c_master_tb;
  localparam int QTR = 2;
  localparam int AW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          irq, scl_pull, sda_pull, sda_in;
  logic          sl_low;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign sda_in = ~(sda_pull | sl_low);

  eeprom_i2c_master #(.QTR_CYCLES(QTR), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_in)
  );

  // ---------------- slave model (bench side) ----------------
  logic [6:0] sl_addr = 7'h53;
  int         nak_at = -1;
  int         clr_seq = 0;
  int         clr_seen = 0;
  logic [7:0] log_b [8];
  int         nlog, n_start, n_stop;
  int         bitc, bidx;
  logic       p_scl, p_sda, tx_mode, rw, ack_given, m_ack_bit;
  logic [7:0] shin, ptr, txb;

  function automatic logic [7:0] mem_val(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    logic scl, sda, ack;
    int   old_b;
    scl = ~scl_pull;
    sda = ~(sda_pull | sl_low);
    if (!rst_n || clr_seq != clr_seen) begin
      clr_seen = clr_seq;
      nlog = 0; n_start = 0; n_stop = 0; bitc = 0; bidx = 0;
      tx_mode = 0; sl_low = 0; rw = 0; ack_given = 0; m_ack_bit = 0;
      shin = 0; ptr = 0; txb = 0;
    end else if (p_scl && scl && p_sda && !sda) begin
      n_start++; bitc = 0; bidx = 0; tx_mode = 0; sl_low = 0;
    end else if (p_scl && scl && !p_sda && sda) begin
      n_stop++; bitc = 0; tx_mode = 0; sl_low = 0;
    end else if (!p_scl && scl) begin
      if (bitc < 8) shin = {shin[6:0], sda};
      else if (tx_mode) m_ack_bit = sda;
      bitc++;
    end else if (p_scl && !scl) begin
      if (bitc == 8) begin
        if (!tx_mode) begin
          if (nlog < 8) log_b[nlog] = shin;
          nlog++;
          ack = (bidx != nak_at) && (bidx != 0 || shin[7:1] == sl_addr);
          if (bidx == 0) rw = shin[0];
          if (bidx == 1 && !rw) ptr = shin;
          ack_given = ack;
          sl_low = ack;
        end else begin
          sl_low = 0;
        end
      end else if (bitc == 9) begin
        old_b = bidx;
        bitc = 0; bidx++; sl_low = 0;
        if (tx_mode) begin
          if (m_ack_bit) tx_mode = 0;
        end else if (old_b == 0 && rw && ack_given) begin
          tx_mode = 1;
          txb = mem_val(ptr);
          if (nlog < 8) log_b[nlog] = txb;
          nlog++;
        end
        if (tx_mode) sl_low = ~txb[7];
      end else if (tx_mode) begin
        sl_low = ~txb[3'd7 - 3'(bitc)];
      end
    end
    p_scl = scl;
    p_sda = sda;
  end

  // SCL run-length monitor
  int run_len = 0;
  int min_h = 9999;
  int min_l = 9999;
  logic m_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (~scl_pull == m_prev) run_len++;
      else begin
        if (m_prev) begin if (run_len < min_h) min_h = run_len; end
        else        begin if (run_len < min_l) min_l = run_len; end
        run_len = 1;
      end
      m_prev = ~scl_pull;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(1, s);
      if ((s & 8'h0A) == 8'h00) break;
    end
  endtask

  task automatic clear_log();
    clr_seq++;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input logic [6:0] devsel, input logic [7:0] wa, input logic [7:0] wd);
    wr(4, {1'b0, devsel});
    wr(5, wa);
    wr(2, wd);
    wr(1, 8'h85);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(a, d);
      chk(d == 8'h00, "R1 register reset", d, 0);
    end
    chk(irq == 1'b0 && scl_pull == 1'b0 && sda_pull == 1'b0, "R1 pins/irq reset",
        {irq, scl_pull, sda_pull}, 0);
  endtask

  task automatic t_write();
    logic [7:0] s;
    sl_addr = 7'h53; nak_at = -1;
    setup(7'h3A, 8'h12, 8'hC7);     // nibble A, chip select 3 -> 0x53
    clear_log();
    wr(1, 8'h02);
    repeat (10) @(negedge clk);
    rd(1, s);
    chk(s == 8'h02, "R5 write start bit held", s, 8'h02);
    wait_idle();
    rd(1, s);
    chk(s == 8'h01, "R5 R7 write done status", s, 8'h01);
    chk(nlog == 3, "R3 byte count", nlog, 3);
    chk(log_b[0] == 8'hA6, "R2 R3 address byte W", log_b[0], 8'hA6);
    chk(log_b[1] == 8'h12, "R3 word address", log_b[1], 8'h12);
    chk(log_b[2] == 8'hC7, "R3 data byte", log_b[2], 8'hC7);
    chk(n_start == 1 && n_stop == 1, "R3 start/stop count", {n_start[15:0], n_stop[15:0]}, 32'h10001);
    chk(!scl_pull && !sda_pull, "R1 released after write", {scl_pull, sda_pull}, 0);
  endtask

  task automatic t_w1c();
    logic [7:0] s;
    wr(1, 8'h00);
    rd(1, s);
    chk(s == 8'h01, "R7 write-0 keeps flag", s, 8'h01);
    wr(1, 8'h01);
    rd(1, s);
    chk(s == 8'h00, "R7 write-1 clears flag", s, 8'h00);
  endtask

  task automatic t_read(input logic [6:0] adr7, input logic [7:0] wa);
    logic [7:0] s, d;
    sl_addr = adr7; nak_at = -1;
    setup({adr7[2:0], adr7[6:3]}, wa, 8'h00);
    clear_log();
    wr(1, 8'h08);
    repeat (10) @(negedge clk);
    rd(1, s);
    chk(s == 8'h08, "R5 read start bit held", s, 8'h08);
    wait_idle();
    rd(1, s);
    chk(s == 8'h04, "R5 R7 read done status", s, 8'h04);
    chk(nlog == 4, "R4 byte count", nlog, 4);
    chk(log_b[0] == {adr7, 1'b0}, "R2 R4 address W", log_b[0], {adr7, 1'b0});
    chk(log_b[1] == wa, "R4 word address", log_b[1], wa);
    chk(log_b[2] == {adr7, 1'b1}, "R2 R4 address R", log_b[2], {adr7, 1'b1});
    chk(n_start == 2 && n_stop == 1, "R4 repeated start", {n_start[15:0], n_stop[15:0]}, 32'h20001);
    chk(m_ack_bit == 1'b1, "R4 master NACK", m_ack_bit, 1);
    rd(3, d);
    chk(d == mem_val(wa), "R4 read data", d, mem_val(wa));
    wr(1, 8'h04);
  endtask

  task automatic t_both_bits();
    logic [7:0] s;
    sl_addr = 7'h53; nak_at = -1;
    setup(7'h3A, 8'h40, 8'h99);
    clear_log();
    wr(1, 8'h0A);
    repeat (6) @(negedge clk);
    rd(1, s);
    chk(s == 8'h02, "R5 both bits -> write only", s, 8'h02);
    wait_idle();
    rd(1, s);
    chk(s == 8'h01 && nlog == 3, "R5 write ran", {s, nlog[7:0]}, {8'h01, 8'h03});
    wr(1, 8'h01);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] s;
    sl_addr = 7'h53; nak_at = -1;
    setup(7'h3A, 8'h21, 8'h5C);
    clear_log();
    wr(1, 8'h02);
    repeat (20) @(negedge clk);
    wr(1, 8'h08);
    rd(1, s);
    chk(s == 8'h02, "R6 read request ignored while busy", s, 8'h02);
    wait_idle();
    repeat (40) @(negedge clk);
    rd(1, s);
    chk(s == 8'h01, "R6 status after busy request", s, 8'h01);
    chk(n_start == 1 && nlog == 3, "R6 single transfer", {n_start[15:0], nlog[15:0]}, 32'h10003);
    wr(1, 8'h01);
  endtask

  task automatic t_nak_addr();
    logic [7:0] s, d0, d1;
    rd(3, d0);
    sl_addr = 7'h11; nak_at = -1;
    setup(7'h3A, 8'h33, 8'h00);
    clear_log();
    wr(1, 8'h08);
    wait_idle();
    rd(1, s);
    chk(s == 8'h84, "R8 address NAK status", s, 8'h84);
    chk(nlog == 1 && n_start == 1 && n_stop == 1, "R8 abort after address",
        {nlog[7:0], n_start[7:0], n_stop[7:0]}, 24'h010101);
    rd(3, d1);
    chk(d1 == d0, "R8 read data kept", d1, d0);
    wr(1, 8'h84);
    rd(1, s);
    chk(s == 8'h00, "R8 NAK flag cleared", s, 8'h00);
  endtask

  task automatic t_nak_data();
    logic [7:0] s;
    sl_addr = 7'h53; nak_at = 2;
    setup(7'h3A, 8'h44, 8'h77);
    clear_log();
    wr(1, 8'h02);
    wait_idle();
    rd(1, s);
    chk(s == 8'h81, "R8 data NAK status", s, 8'h81);
    chk(nlog == 3 && n_stop == 1, "R8 stop after data NAK", {nlog[15:0], n_stop[15:0]}, 32'h30001);
    wr(1, 8'h81);
    nak_at = -1;
  endtask

  task automatic t_irq();
    sl_addr = 7'h53; nak_at = -1;
    setup(7'h3A, 8'h05, 8'h06);
    wr(0, 8'h83);
    chk(irq == 1'b0, "R9 no flag no irq", irq, 0);
    wr(1, 8'h02);
    wait_idle();
    @(negedge clk);
    chk(irq == 1'b1, "R9 write finish irq", irq, 1);
    wr(0, 8'h82);
    @(negedge clk);
    chk(irq == 1'b0, "R9 write enable off", irq, 0);
    wr(0, 8'h03);
    @(negedge clk);
    chk(irq == 1'b0, "R9 global enable off", irq, 0);
    wr(1, 8'h01);
    wr(0, 8'h82);
    wr(1, 8'h08);
    wait_idle();
    @(negedge clk);
    chk(irq == 1'b1, "R9 read finish irq", irq, 1);
    wr(1, 8'h04);
    @(negedge clk);
    chk(irq == 1'b0, "R9 irq drops on clear", irq, 0);
    wr(0, 8'h00);
  endtask

  task automatic t_timing();
    chk(min_h >= 2 * QTR, "R10 SCL high time", min_h, 2 * QTR);
    chk(min_l >= 2 * QTR, "R10 SCL low time", min_l, 2 * QTR);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_w1c();
    t_read(7'h53, 8'h3C);
    t_read(7'h2E, 8'hF0);   // devsel nibble 5, chip select 6
    t_both_bits();
    t_busy_ignore();
    t_nak_addr();
    t_nak_data();
    t_irq();
    t_timing();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end
endmodule